// File: doc/BRIEF.md
# Reloadable Interval Tick Timer

This block raises a periodic interrupt whose rate software chooses by writing a reload value. The rate is 1000 / (reload + 1) ticks per second, with integer division. The period in clock cycles is the clock frequency divided by that rate. The clock frequency is a parameter. When a period ends, the interrupt goes high and the next period begins at once. The interrupt stays high until software acknowledges it.

Software reaches the block through a simple word-addressed register port. Writing the reload location does three things: it stores the value, drops any pending interrupt and restarts timing. Reading the count location always returns zero, and that read is the acknowledge.

Each reload write produces a new period length. A shared iterative divider computes it over a fixed number of cycles, and a register then holds the result. No divider sits in the per-cycle counting path. While that calculation runs, the counter is held at zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the interrupt is low, the reload value reads 0, and the first tick arrives CLK_HZ/1000 cycles after the last clock edge seen in reset.
- R2: For a reload value r below 1000, the period is P = CLK_HZ / (1000 / (r + 1)) cycles, each division truncating.
- R3: A write to byte offset 0x228 stores the reload value. A read of offset 0x228 returns it with no side effect. Decoding ignores address bits [1:0].
- R4: A reload write lowers the interrupt on its own clock edge and restarts timing. The first tick rises 2*W + 2 + P edges after the write edge, where W = max(10, ceil(log2(CLK_HZ + 1))). A second write during the calculation restarts that count.
- R5: The interrupt rises at the end of every period, and periods follow one another with no gap. Starting the next period does not clear a raised interrupt, which stays high until it is acknowledged.
- R6: A read of byte offset 0x230 returns 0 and lowers the interrupt on that clock edge.
- R7: If an acknowledge read and an expiry fall on the same edge, the expiry wins and the interrupt stays high.
- R8: A reload value of 1000 or more, including 0xFFFFFFFF, gives a period of 2^CNT_W - 1 cycles.
- R9: A computed period larger than 2^CNT_W - 1 is clamped to 2^CNT_W - 1, and a computed period of zero becomes 1.
- R10: Writes to any other offset change nothing: not the interrupt, not the stored reload, not the tick timing. Reads of any offset other than 0x228 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock running at CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of bus_rd |
| tick_irq | output | 1 | Level interrupt, high from an expiry until acknowledged |

## Verification
A wrong period register shows up as a tick that is early or late by a fixed number of cycles. The error appears on the first tick after a reload write and repeats on every later one. A mis-sequenced divider or calculation state shifts that first tick away from 2*W + 2 + P edges. A counter that does not wrap, or that gets stuck, either misses the next tick or produces ticks too close together within one period. A wrong interrupt priority shows up within a single edge: when an acknowledge meets an expiry, or when a write is made while the interrupt is high.

// File: rtl/tick_pkg.sv
// Package tick_pkg
// Shared constants and types for the interval tick timer.
// Assumes byte addressing with 32-bit word registers.
package tick_pkg;

    // numerator of the tick-rate formula (ticks per second at reload 0)
    localparam int unsigned RATE_NUM = 1000;

    // byte offsets of the two decoded registers
    localparam int unsigned REG_RELOAD_OFS = 32'h228;
    localparam int unsigned REG_COUNT_OFS  = 32'h230;

    // sequencing of the period calculation
    typedef enum logic [1:0] {
        CALC_IDLE,
        CALC_FREQ,
        CALC_CYC
    } calc_state_e;

endpackage

// File: rtl/tick_divider.sv
// Module tick_divider
// Unsigned restoring divider that produces one quotient bit per cycle.
// A start pulse loads the operands, even while a division is running.
// done pulses for one cycle W cycles after start, and quot is valid from then on.
// A zero divisor yields an all-ones quotient; callers must not rely on it.
module tick_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] numer,
    input  logic [W-1:0] denom,
    output logic         done,
    output logic [W-1:0] quot
);

    localparam int SW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [SW-1:0] steps_q;
    logic          busy_q;
    logic          done_q;

    logic [W:0]    trial;
    logic          fits;
    logic [W-1:0]  diff;

    // one trial subtraction of the shifted partial remainder
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        fits  = (trial >= {1'b0, den_q});
        diff  = trial[W-1:0] - den_q;
    end

    // operand load and iteration sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            steps_q <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q  <= 1'b1;
                steps_q <= SW'(W);
                rem_q   <= '0;
                quo_q   <= numer;
                den_q   <= denom;
            end else if (busy_q) begin
                rem_q   <= fits ? diff : trial[W-1:0];
                quo_q   <= {quo_q[W-2:0], fits};
                steps_q <= steps_q - 1'b1;
                if (steps_q == SW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = quo_q;

endmodule

// File: rtl/tick_period_calc.sv
// Module tick_period_calc
// Turns a reload value into a period in cycles, using two passes of one shared divider:
// rate = RATE_NUM/(reload+1), then period = CLK_HZ/rate.
// A reload of RATE_NUM or more would give a zero rate, so it selects the
// longest period instead. The result is clamped to [1, 2^CNT_W-1].
// Assumes CLK_HZ fits in DIV_W bits and DIV_W <= DATA_W.
module tick_period_calc
    import tick_pkg::*;
#(
    parameter longint CLK_HZ = 50000,
    parameter int     CNT_W  = 16,
    parameter int     DATA_W = 32,
    parameter int     DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic              busy,
    output logic [CNT_W-1:0]  period
);

    localparam longint P_MAX_I  = (64'd1 << CNT_W) - 1;
    localparam longint P0_RAW   = CLK_HZ / RATE_NUM;
    localparam longint P0_I     = (P0_RAW == 0) ? 1 :
                                  ((P0_RAW > P_MAX_I) ? P_MAX_I : P0_RAW);
    localparam logic [CNT_W-1:0] P_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] P_INIT = CNT_W'(P0_I);

    calc_state_e      state_q;
    logic             over_q;
    logic [CNT_W-1:0] period_q;

    logic             load_over;
    logic             div_start;
    logic [DIV_W-1:0] div_numer;
    logic [DIV_W-1:0] div_denom;
    logic             div_done;
    logic [DIV_W-1:0] div_quot;
    logic [63:0]      quot_ext;
    logic [CNT_W-1:0] period_nxt;

    // zero-rate detection on the written value
    assign load_over = (load_val >= DATA_W'(RATE_NUM));

    // operand selection for the shared divider
    always_comb begin
        div_start = load | ((state_q == CALC_FREQ) & div_done);
        div_numer = load ? DIV_W'(RATE_NUM) : DIV_W'(CLK_HZ);
        if (load)
            div_denom = load_val[DIV_W-1:0] + 1'b1;
        else if (over_q)
            div_denom = DIV_W'(1);
        else
            div_denom = div_quot;
    end

    tick_divider #(
        .W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .numer (div_numer),
        .denom (div_denom),
        .done  (div_done),
        .quot  (div_quot)
    );

    // clamp of the second quotient into the counter range
    always_comb begin
        quot_ext = 64'(div_quot);
        if (over_q || (quot_ext > 64'(P_MAX_I)))
            period_nxt = P_MAX;
        else if (div_quot == '0)
            period_nxt = CNT_W'(1);
        else
            period_nxt = CNT_W'(div_quot);
    end

    // calculation sequencing and period register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CALC_IDLE;
            over_q   <= 1'b0;
            period_q <= P_INIT;
        end else if (load) begin
            state_q <= CALC_FREQ;
            over_q  <= load_over;
        end else begin
            case (state_q)
                CALC_FREQ: if (div_done) state_q <= CALC_CYC;
                CALC_CYC: begin
                    if (div_done) begin
                        period_q <= period_nxt;
                        state_q  <= CALC_IDLE;
                    end
                end
                default: state_q <= CALC_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != CALC_IDLE);
    assign period = period_q;

endmodule

// File: rtl/tick_counter.sv
// Module tick_counter
// Counts cycles from 0 to period-1 and flags an expiry on the last one.
// It wraps straight back to 0 so that periods follow one another with no gap.
// hold forces the count to 0 and suppresses expiry. Assumes period >= 1.
module tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] period,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_q;

    // expiry on the final cycle of a period
    assign expire = !hold && (cnt_q == period - 1'b1);

    // cycle count with restart and wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hold || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

endmodule

// File: rtl/tick_regs.sv
// Module tick_regs
// Register decode, the reload register and the interrupt flag.
// Decoding works on words: address bits [1:0] are ignored.
// Read data is combinational. Only the reload location returns data.
// Assumes that reads and writes are single-cycle strobes.
module tick_regs
    import tick_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              expire,
    output logic              reload_wr,
    output logic              count_ack,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] RELOAD_A = ADDR_W'(REG_RELOAD_OFS) | LOW_MASK;
    localparam logic [ADDR_W-1:0] COUNT_A  = ADDR_W'(REG_COUNT_OFS) | LOW_MASK;

    logic              hit_reload;
    logic              hit_count;
    logic [DATA_W-1:0] reload_q;
    logic              irq_q;

    // word decode of the two locations
    assign hit_reload = ((addr | LOW_MASK) == RELOAD_A);
    assign hit_count  = ((addr | LOW_MASK) == COUNT_A);
    assign reload_wr  = wr_en & hit_reload;
    assign count_ack  = rd_en & hit_count;

    // read path: only the reload value is visible
    assign rdata = (rd_en && hit_reload) ? reload_q : '0;

    // reload storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (reload_wr)
            reload_q <= wdata;
    end

    // interrupt flag: an expiry outranks both clearing causes
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (expire)
            irq_q <= 1'b1;
        else if (reload_wr || count_ack)
            irq_q <= 1'b0;
    end

    assign irq = irq_q;

endmodule

// File: rtl/tick_timer.sv
// Module tick_timer (top)
// Periodic interrupt source whose rate software sets through a reload register.
// Each reload write starts a period calculation, and the counter stays at zero
// until that calculation ends. Assumes CLK_HZ < 2^DATA_W and CNT_W <= 62.
module tick_timer
    import tick_pkg::*;
#(
    parameter longint CLK_HZ = 50000,
    parameter int     CNT_W  = 16,
    parameter int     ADDR_W = 14,
    parameter int     DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);

    localparam int HZ_BITS = $clog2(CLK_HZ + 1);
    localparam int DIV_W   = (HZ_BITS > 10) ? HZ_BITS : 10;

    logic             reload_wr;
    logic             count_ack;
    logic             calc_busy;
    logic             cnt_hold;
    logic             expire;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt_val;

    // the counter restarts on a write and waits for the new period
    assign cnt_hold = reload_wr | calc_busy;

    tick_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr_en     (bus_wr),
        .wdata     (bus_wdata),
        .rd_en     (bus_rd),
        .rdata     (bus_rdata),
        .expire    (expire),
        .reload_wr (reload_wr),
        .count_ack (count_ack),
        .irq       (tick_irq)
    );

    tick_period_calc #(
        .CLK_HZ (CLK_HZ),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W)
    ) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload_wr),
        .load_val (bus_wdata),
        .busy     (calc_busy),
        .period   (period)
    );

    tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (cnt_hold),
        .period (period),
        .expire (expire),
        .count  (cnt_val)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Module tick_timer_chk
// Temporal checks on the tick timer, attached to every tick_timer by bind.
module tick_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             expire,
    input logic             reload_wr,
    input logic             count_ack,
    input logic             calc_busy,
    input logic             irq,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] period
);

    // R5
    tick_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    // R5
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !count_ack && !reload_wr) |=> irq);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_ack && !expire) |=> !irq);

    // R4
    reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (!irq && cnt_val == '0));

    // R4
    calc_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_busy |-> (!expire && cnt_val == '0));

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) && (cnt_val < period));

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .reload_wr (reload_wr),
    .count_ack (count_ack),
    .calc_busy (calc_busy),
    .irq       (tick_irq),
    .cnt_val   (cnt_val),
    .period    (period)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;

    localparam longint CLK_HZ = 50000;
    localparam int     CNT_W  = 12;
    localparam int     PMAX   = 4095;
    localparam int     LAT    = 34;          // 2*W+2 with W = 16
    localparam logic [13:0] A_RELOAD = 14'h228;
    localparam logic [13:0] A_COUNT  = 14'h230;
    localparam logic [13:0] A_OTHER  = 14'h22C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tick_timer #(
        .CLK_HZ (CLK_HZ),
        .CNT_W  (CNT_W),
        .ADDR_W (14),
        .DATA_W (32)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rd    (rd),
        .bus_rdata (rdata),
        .tick_irq  (irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input longint r);
        longint f, p;
        if (r >= 1000) return PMAX;
        f = 1000 / (r + 1);
        p = CLK_HZ / f;
        if (p > PMAX) p = PMAX;
        if (p == 0) p = 1;
        return int'(p);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic bus_write(input logic [13:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        e = cyc;
    endtask

    task automatic bus_read(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_rise(input int limit, output int x);
        int n = 0;
        while (!irq && n < limit) begin
            @(negedge clk);
            n++;
        end
        x = irq ? cyc : -1;
    endtask

    task automatic ack(input string req);
        logic [31:0] d;
        bus_read(A_COUNT, d);
        check({req, " count reads zero"}, d, 0);
        check({req, " irq cleared by count read"}, irq, 0);
    endtask

    // R1: reset state and first tick
    task automatic t_reset();
        int l, x;
        logic [31:0] d;
        check("R1 irq low in reset", irq, 0);
        @(negedge clk);
        rst_n = 1'b1;
        l = cyc;
        bus_read(A_RELOAD, d);
        check("R1 reload reads 0 after reset", d, 0);
        wait_rise(1000, x);
        check("R1 first tick delay", x - l, exp_period(0));
        ack("R6");
    endtask

    // R2 R3 R4 R5: timing after a reload write
    task automatic t_period(input logic [31:0] r);
        int e, x, x2, p;
        logic [31:0] d;
        p = exp_period(r);
        bus_write(A_RELOAD, r, e);
        check("R4 irq low after write", irq, 0);
        wait_rise(20000, x);
        check("R2 R4 first tick after write", x - e, LAT + p);
        bus_read(A_RELOAD, d);
        check("R3 reload readback", d, r);
        ack("R6");
        wait_rise(20000, x2);
        check("R5 back-to-back period", x2 - x, p);
        ack("R6");
    endtask

    // R5 R7: sticky interrupt and expiry winning over an acknowledge
    task automatic t_sticky(input int p);
        int x, drops = 0;
        wait_rise(20000, x);
        while (cyc < x + p - 1) begin
            @(negedge clk);
            if (!irq) drops++;
        end
        check("R5 irq held across next period start", drops, 0);
        addr = A_COUNT; rd = 1'b1;
        @(negedge clk);
        check("R7 same-edge ack and expiry keeps irq", irq, 1);
        check("R7 edge alignment", cyc, x + p);
        @(negedge clk);
        rd = 1'b0;
        check("R6 later ack clears irq", irq, 0);
    endtask

    // R4: a reload write clears a pending tick; a rewrite during calculation restarts
    task automatic t_reload_clear();
        int x, e, e2;
        wait_rise(20000, x);
        bus_write(A_RELOAD, 32'd4, e);
        check("R4 write clears pending irq", irq, 0);
        wait_rise(20000, x);
        check("R4 timing after clearing write", x - e, LAT + exp_period(4));
        ack("R6");
        bus_write(A_RELOAD, 32'd1, e);
        repeat (5) @(negedge clk);
        bus_write(A_RELOAD, 32'd3, e2);
        wait_rise(20000, x);
        check("R4 rewrite during calc restarts", x - e2, LAT + exp_period(3));
        ack("R6");
    endtask

    // R10: writes elsewhere are ignored, reads elsewhere return zero
    task automatic t_ignored(input int p);
        int x, x2, e;
        logic [31:0] d;
        wait_rise(20000, x);
        bus_write(A_OTHER, 32'd7, e);
        check("R10 other write leaves irq", irq, 1);
        bus_read(A_RELOAD, d);
        check("R10 reload unchanged", d, 3);
        bus_read(A_OTHER, d);
        check("R10 other read returns 0", d, 0);
        ack("R6");
        wait_rise(20000, x2);
        check("R10 tick timing unchanged", x2 - x, p);
        ack("R6");
    endtask

    // R8 R9: clamping of long periods
    task automatic t_clamp(input logic [31:0] r, input string req);
        int e, x;
        bus_write(A_RELOAD, r, e);
        wait_rise(10000, x);
        check({req, " clamped period"}, x - e, LAT + PMAX);
        ack("R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_period(32'd1);
        t_period(32'd6);
        t_period(32'd9);
        t_sticky(exp_period(9));
        t_reload_clear();
        t_ignored(exp_period(3));
        t_clamp(32'd999, "R9");
        t_clamp(32'd1000, "R8");
        t_clamp(32'hFFFF_FFFF, "R8");
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule